// File: doc/BRIEF.md
# Key-Unlocked Buffered Program-Memory Write Controller

This controller lets a small processor rewrite its own program memory. Software first loads a target address and a data word. It then writes a two-byte key to a key register and issues a start request through a control write that also selects program memory. Words go into an eight-slot staging buffer indexed by the low three address bits. A request aimed at any slot except the last one simply fills that slot and finishes after a short setup window. A request aimed at the last slot of an aligned eight-word block does more. It clears a sixteen-word aligned row of the array to all ones, then writes the eight buffered words into the block. During that whole phase it holds the processor in a stall.

Every request is checked against a protected address region, which a two-bit configuration input selects. Rejected requests raise an error flag and leave the buffer and the array untouched. The array itself sits outside the block and is reached through an erase strobe and a word-program strobe that share one address bus. The stall length is a parameter in clock cycles, so a real part can use milliseconds and a simulation can use a few cycles.

Top module: `flash_selfwrite`

## Requirements
- R1: A start request (`ctl_we`=1 with `ctl_start`=1 while idle) is accepted only if `ctl_pgm_sel`=1 in that same write and the controller is unlocked. Unlocked means the two most recent key writes were 0x55 and then 0xAA, with nothing between them. Any other start request raises `err` and changes nothing else.
- R2: A key write of any value that does not continue the 0x55, 0xAA pair drops the unlock. Every start request uses up the unlock, whether it is accepted or rejected, so a second start needs a new key pair.
- R3: An accepted request with address bits [2:0] not equal to 111 stores the data word in buffer slot addr[2:0]. `done` is high for one cycle, SETUP_CYCLES clock edges after the accepting edge. There is no stall and no array access.
- R4: An accepted request with address bits [2:0] = 111 raises `stall` at that same point and holds it for STALL_CYCLES cycles. In the first stall cycle it issues one erase strobe. In the next eight cycles it issues program strobes for slots 0 through 7, in that order, to block address {addr[7:3], slot}. `done` rises as `stall` falls.
- R5: The erase strobe carries the sixteen-word row base, with address bits [3:0] = 0. Every word of that row becomes all ones before the program strobes, including the eight words that lie outside the target block.
- R6: Protect encoding `prot_cfg`: 00 protects nothing, 01 protects the lowest quarter of the array, 10 the lowest half, 11 all of it. A request to a protected address raises `err` and changes neither the buffer nor the array.
- R7: `wr_busy` is high from the cycle after acceptance until the cycle in which `done` is high, and is low in that cycle. `done` lasts one cycle. An accepted request clears `err`.
- R8: While `wr_busy` is high, writes to the address, data, key and control inputs are ignored.
- R9: The controller never merges old array data into the buffer. A slot that was not written keeps its earlier buffer contents, and the buffer resets to all ones.
- R10: After reset `wr_busy`, `done`, `err`, `stall`, `arr_erase` and `arr_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_cfg | input | 2 | Protected region select, stable while out of reset |
| addr_we | input | 1 | Load strobe for the address register |
| addr_wdata | input | ADDR_W | Target word address |
| data_we | input | 1 | Load strobe for the data register |
| data_wdata | input | DATA_W | Word to be written |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_pgm_sel | input | 1 | Program-memory select carried by the control write |
| ctl_start | input | 1 | Start request carried by the control write |
| wr_busy | output | 1 | Start bit read-back, high while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky rejection flag |
| stall | output | 1 | Core halt during erase and program |
| arr_erase | output | 1 | Row erase strobe to the array |
| arr_we | output | 1 | Word program strobe to the array |
| arr_addr | output | ADDR_W | Array address for the erase or program strobe |
| arr_wdata | output | DATA_W | Word to program |

## Verification
The assertions assume that inputs change only between clock edges and that `prot_cfg` stays fixed while reset is released. They also rely on the array model treating an erase strobe as clearing sixteen words starting at the given base. The bench drives every strobe at the falling edge and holds each one for exactly one cycle. It changes the protect setting only while reset is asserted. It deliberately injects key, address and start writes in the middle of a stall, and checks at the ports that they have no effect.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   typedef enum logic [1:0] {
      KEY_IDLE = 2'd0,
      KEY_HALF = 2'd1,
      KEY_OPEN = 2'd2
   } key_st_t;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_SETUP  = 2'd1,
      SEQ_COMMIT = 2'd2
   } seq_st_t;

   typedef enum logic [1:0] {
      PROT_NONE    = 2'd0,
      PROT_QUARTER = 2'd1,
      PROT_HALF    = 2'd2,
      PROT_ALL     = 2'd3
   } prot_t;

endpackage

// File: rtl/fsw_unlock.sv
module fsw_unlock
   import fsw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       key_we,
   input  logic [7:0] key_wdata,
   input  logic       consume,
   output logic       open
);

   key_st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (consume) begin
         st_d = KEY_IDLE;
      end else if (key_we && !busy) begin
         if (key_wdata == KEY_FIRST)
            st_d = KEY_HALF;
         else if (key_wdata == KEY_SECOND && st_q == KEY_HALF)
            st_d = KEY_OPEN;
         else
            st_d = KEY_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KEY_IDLE;
      else        st_q <= st_d;
   end

   assign open = (st_q == KEY_OPEN);

endmodule

// File: rtl/fsw_guard.sv
module fsw_guard
   import fsw_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [1:0]        prot_cfg,
   input  logic [ADDR_W-1:0] addr,
   output logic              blocked
);

   logic in_quarter;
   logic in_half;

   assign in_half    = (addr[ADDR_W-1] == 1'b0);
   assign in_quarter = (addr[ADDR_W-1 -: 2] == 2'b00);

   always_comb begin
      case (prot_t'(prot_cfg))
         PROT_NONE:    blocked = 1'b0;
         PROT_QUARTER: blocked = in_quarter;
         PROT_HALF:    blocked = in_half;
         default:      blocked = 1'b1;
      endcase
   end

endmodule

// File: rtl/fsw_wbuf.sv
module fsw_wbuf #(
   parameter int DATA_W = 14,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_data
);

   localparam int SLOTS = 1 << SLOT_W;

   logic [DATA_W-1:0] slot_word [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (wr_en && wr_slot == SLOT_W'(g))
            word_q <= wr_data;
      end
      assign slot_word[g] = word_q;
   end

   assign rd_data = slot_word[rd_slot];

endmodule

// File: rtl/fsw_seq.sv
module fsw_seq
   import fsw_pkg::*;
#(
   parameter int SLOT_W       = 3,
   parameter int SETUP_CYCLES = 2,
   parameter int STALL_CYCLES = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok,
   input  logic              last_slot,
   output logic              busy,
   output logic              buf_wr,
   output logic              done,
   output logic              stall,
   output logic              arr_erase,
   output logic              arr_we,
   output logic [SLOT_W-1:0] prog_idx
);

   localparam int SLOTS   = 1 << SLOT_W;
   localparam int CNT_MAX = (STALL_CYCLES > SETUP_CYCLES) ? STALL_CYCLES : SETUP_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   seq_st_t          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_m1;
   logic             setup_end;
   logic             commit_end;

   assign setup_end  = (st_q == SEQ_SETUP)  && (cnt_q == CNT_W'(SETUP_CYCLES - 1));
   assign commit_end = (st_q == SEQ_COMMIT) && (cnt_q == CNT_W'(STALL_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            SEQ_IDLE: begin
               if (start_ok) begin
                  st_q  <= SEQ_SETUP;
                  cnt_q <= '0;
               end
            end
            SEQ_SETUP: begin
               if (setup_end) begin
                  cnt_q <= '0;
                  if (last_slot) begin
                     st_q <= SEQ_COMMIT;
                  end else begin
                     st_q <= SEQ_IDLE;
                     done <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            SEQ_COMMIT: begin
               if (commit_end) begin
                  st_q  <= SEQ_IDLE;
                  cnt_q <= '0;
                  done  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign cnt_m1    = cnt_q - CNT_W'(1);
   assign busy      = (st_q != SEQ_IDLE);
   assign buf_wr    = setup_end;
   assign stall     = (st_q == SEQ_COMMIT);
   assign arr_erase = stall && (cnt_q == '0);
   assign arr_we    = stall && (cnt_q != '0) && (cnt_q <= CNT_W'(SLOTS));
   assign prog_idx  = cnt_m1[SLOT_W-1:0];

endmodule

// File: rtl/flash_selfwrite.sv
module flash_selfwrite
   import fsw_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 14,
   parameter int SLOT_W       = 3,
   parameter int SETUP_CYCLES = 2,
   parameter int STALL_CYCLES = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        prot_cfg,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              key_we,
   input  logic [7:0]        key_wdata,
   input  logic              ctl_we,
   input  logic              ctl_pgm_sel,
   input  logic              ctl_start,
   output logic              wr_busy,
   output logic              done,
   output logic              err,
   output logic              stall,
   output logic              arr_erase,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata
);

   localparam int ROW_LSB = SLOT_W + 1;

   if (SLOT_W < 1) begin : g_bad_slot
      $error("SLOT_W must be at least 1");
   end
   if (ADDR_W < SLOT_W + 3) begin : g_bad_addr
      $error("ADDR_W too small for quarter-aligned protection of an erase row");
   end
   if (SETUP_CYCLES < 1) begin : g_bad_setup
      $error("SETUP_CYCLES must be at least 1");
   end
   if (STALL_CYCLES < (1 << SLOT_W) + 2) begin : g_bad_stall
      $error("STALL_CYCLES must cover erase and every program strobe");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              key_open;
   logic              blocked;
   logic              start_req;
   logic              start_ok;
   logic              busy;
   logic              buf_wr;
   logic [SLOT_W-1:0] prog_idx;
   logic [DATA_W-1:0] buf_rd;

   assign start_req = ctl_we && ctl_start && !busy;
   assign start_ok  = start_req && ctl_pgm_sel && key_open && !blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
      end else begin
         if (addr_we && !busy) addr_q <= addr_wdata;
         if (data_we && !busy) data_q <= data_wdata;
         if (start_ok)       err_q <= 1'b0;
         else if (start_req) err_q <= 1'b1;
      end
   end

   fsw_unlock u_unlock (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .key_we    (key_we),
      .key_wdata (key_wdata),
      .consume   (start_req),
      .open      (key_open)
   );

   fsw_guard #(.ADDR_W(ADDR_W)) u_guard (
      .prot_cfg (prot_cfg),
      .addr     (addr_q),
      .blocked  (blocked)
   );

   fsw_wbuf #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_wbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (buf_wr),
      .wr_slot (addr_q[SLOT_W-1:0]),
      .wr_data (data_q),
      .rd_slot (prog_idx),
      .rd_data (buf_rd)
   );

   fsw_seq #(
      .SLOT_W       (SLOT_W),
      .SETUP_CYCLES (SETUP_CYCLES),
      .STALL_CYCLES (STALL_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_ok  (start_ok),
      .last_slot (&addr_q[SLOT_W-1:0]),
      .busy      (busy),
      .buf_wr    (buf_wr),
      .done      (done),
      .stall     (stall),
      .arr_erase (arr_erase),
      .arr_we    (arr_we),
      .prog_idx  (prog_idx)
   );

   always_comb begin
      if (arr_erase)
         arr_addr = {addr_q[ADDR_W-1:ROW_LSB], {ROW_LSB{1'b0}}};
      else
         arr_addr = {addr_q[ADDR_W-1:SLOT_W], prog_idx};
   end

   assign arr_wdata = buf_rd;
   assign wr_busy   = busy;
   assign err       = err_q;

endmodule

// File: rtl/flash_selfwrite_chk.sv
module flash_selfwrite_chk #(
   parameter int ADDR_W       = 8,
   parameter int SLOT_W       = 3,
   parameter int STALL_CYCLES = 20000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              stall,
   input logic              wr_busy,
   input logic              err,
   input logic              arr_we,
   input logic              arr_erase,
   input logic [ADDR_W-1:0] arr_addr,
   input logic              key_open,
   input logic              ctl_we,
   input logic              ctl_start
);

   logic [31:0] stall_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stall_len <= '0;
      else if (stall) stall_len <= stall_len + 32'd1;
      else            stall_len <= '0;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_busy); // R7
   AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> wr_busy); // R4
   AST_ARR_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we || arr_erase) |-> stall); // R4
   AST_ARR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({arr_we, arr_erase})); // R4
   AST_ERASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      arr_erase |-> (arr_addr[SLOT_W:0] == '0)); // R5
   AST_STALL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> (stall_len == 32'(STALL_CYCLES))); // R4
   AST_STALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> done); // R4
   AST_ACCEPT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(key_open)); // R1
   AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_start && !wr_busy && !key_open) |=> (err && !wr_busy)); // R1

endmodule

bind flash_selfwrite flash_selfwrite_chk #(
   .ADDR_W       (ADDR_W),
   .SLOT_W       (SLOT_W),
   .STALL_CYCLES (STALL_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done      (done),
   .stall     (stall),
   .wr_busy   (wr_busy),
   .err       (err),
   .arr_we    (arr_we),
   .arr_erase (arr_erase),
   .arr_addr  (arr_addr),
   .key_open  (key_open),
   .ctl_we    (ctl_we),
   .ctl_start (ctl_start)
);

// File: tb/flash_selfwrite_test.sv
module flash_selfwrite_test;

   localparam int AW    = 8;
   localparam int DW    = 14;
   localparam int SETUP = 2;
   localparam int S     = 12;
   localparam int DEPTH = 1 << AW;
   localparam int VW    = AW + DW + 4;
   localparam int NVEC  = 12;

   // entry: {address, data, key mode (0 good, 1 broken, 2 none), pgm select, expect accept}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {8'h10, 14'h0A01, 2'd0, 1'b1, 1'b1},
      {8'h11, 14'h0A02, 2'd0, 1'b1, 1'b1},
      {8'h12, 14'h0A03, 2'd0, 1'b1, 1'b1},
      {8'h13, 14'h0A04, 2'd1, 1'b1, 1'b0},
      {8'h13, 14'h0A04, 2'd0, 1'b1, 1'b1},
      {8'h14, 14'h0A05, 2'd2, 1'b1, 1'b0},
      {8'h14, 14'h0A05, 2'd0, 1'b0, 1'b0},
      {8'h14, 14'h0A05, 2'd0, 1'b1, 1'b1},
      {8'h17, 14'h0A08, 2'd0, 1'b1, 1'b1},
      {8'h1F, 14'h1234, 2'd0, 1'b1, 1'b1},
      {8'h25, 14'h0BBB, 2'd0, 1'b1, 1'b1},
      {8'h27, 14'h0CCC, 2'd0, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    prot_cfg = 2'b00;
   logic          addr_we = 1'b0;
   logic [AW-1:0] addr_wdata = '0;
   logic          data_we = 1'b0;
   logic [DW-1:0] data_wdata = '0;
   logic          key_we = 1'b0;
   logic [7:0]    key_wdata = '0;
   logic          ctl_we = 1'b0;
   logic          ctl_pgm_sel = 1'b0;
   logic          ctl_start = 1'b0;
   logic          wr_busy, done, err, stall, arr_erase, arr_we;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata;

   int checks = 0;
   int fails  = 0;

   logic [DW-1:0] mem     [DEPTH];
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] ref_buf [8];

   always #2.5 clk = ~clk;

   flash_selfwrite #(
      .ADDR_W(AW), .DATA_W(DW), .SLOT_W(3), .SETUP_CYCLES(SETUP), .STALL_CYCLES(S)
   ) uut (
      .clk(clk), .rst_n(rst_n), .prot_cfg(prot_cfg),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .data_we(data_we), .data_wdata(data_wdata),
      .key_we(key_we), .key_wdata(key_wdata),
      .ctl_we(ctl_we), .ctl_pgm_sel(ctl_pgm_sel), .ctl_start(ctl_start),
      .wr_busy(wr_busy), .done(done), .err(err), .stall(stall),
      .arr_erase(arr_erase), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
   );

   // behavioural array: erase clears sixteen words to all ones
   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 3 + 7);
      forever begin
         @(posedge clk);
         if (arr_erase)
            for (int j = 0; j < 16; j++) mem[(int'(arr_addr) + j) % DEPTH] <= '1;
         if (arr_we) mem[arr_addr] <= arr_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic mem_cmp(input string tag);
      int diffs = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] !== ref_mem[i]) diffs++;
      chk(diffs == 0, tag, "array words differing from model", diffs, 0);
   endtask

   task automatic ref_apply(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int row, blk;
      ref_buf[a[2:0]] = d;
      if (a[2:0] == 3'd7) begin
         row = int'(a) & ~15;
         blk = int'(a) & ~7;
         for (int j = 0; j < 16; j++) ref_mem[row + j] = '1;
         for (int j = 0; j < 8; j++)  ref_mem[blk + j] = ref_buf[j];
      end
   endtask

   task automatic key_put(input logic [7:0] v);
      key_we = 1'b1; key_wdata = v;
      @(negedge clk);
      key_we = 1'b0;
   endtask

   task automatic do_reset(input logic [1:0] cfg);
      @(negedge clk);
      rst_n = 1'b0; prot_cfg = cfg;
      for (int j = 0; j < 8; j++) ref_buf[j] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({wr_busy, done, err, stall, arr_erase, arr_we} == 6'b0, "R10",
          "outputs after reset", int'({wr_busy, done, err, stall, arr_erase, arr_we}), 0);
   endtask

   task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int km,
                            input bit sel, input bit acc, input bit load, input bit inject,
                            input string tag);
      bit last = (a[2:0] == 3'd7);
      int done_k = 0, stall_n = 0, acts = 0, dones = 0;
      @(negedge clk);
      if (load) begin
         addr_we = 1'b1; addr_wdata = a; data_we = 1'b1; data_wdata = d;
         @(negedge clk);
         addr_we = 1'b0; data_we = 1'b0;
      end
      if (km == 0) begin key_put(8'h55); key_put(8'hAA); end
      if (km == 1) begin key_put(8'h55); key_put(8'h00); key_put(8'hAA); end
      ctl_we = 1'b1; ctl_start = 1'b1; ctl_pgm_sel = sel;
      @(negedge clk);
      ctl_we = 1'b0; ctl_start = 1'b0; ctl_pgm_sel = 1'b0;
      if (acc) begin
         chk(err == 1'b0, "R7", {tag, " err cleared on accept"}, int'(err), 0);
         chk(wr_busy == 1'b1, "R7", {tag, " busy after accept"}, int'(wr_busy), 1);
         for (int k = 1; k <= S + 8; k++) begin
            if (done && done_k == 0) done_k = k;
            if (done) dones++;
            if (stall) stall_n++;
            if (arr_we || arr_erase) acts++;
            if (inject) begin
               key_we = (k == 3 || k == 4); key_wdata = (k == 3) ? 8'h55 : 8'hAA;
               addr_we = (k == 3); addr_wdata = 8'h30;
               data_we = (k == 3); data_wdata = 14'h3333;
               ctl_we = (k == 5); ctl_start = (k == 5); ctl_pgm_sel = (k == 5);
            end
            @(negedge clk);
         end
         key_we = 1'b0; addr_we = 1'b0; data_we = 1'b0; ctl_we = 1'b0; ctl_start = 1'b0; ctl_pgm_sel = 1'b0;
         chk(done_k == (last ? SETUP + 1 + S : SETUP + 1), last ? "R4" : "R3",
             {tag, " done cycle"}, done_k, last ? SETUP + 1 + S : SETUP + 1);
         chk(dones == 1, "R7", {tag, " done pulses"}, dones, 1);
         chk(stall_n == (last ? S : 0), last ? "R4" : "R3", {tag, " stall cycles"}, stall_n, last ? S : 0);
         chk(acts == (last ? 9 : 0), last ? "R4" : "R3", {tag, " array strobes"}, acts, last ? 9 : 0);
         if (inject) chk(err == 1'b0, "R8", "start during stall ignored", int'(err), 0);
         ref_apply(a, d);
      end else begin
         chk(err == 1'b1, tag, "err after refused start", int'(err), 1);
         chk(wr_busy == 1'b0, tag, "busy after refused start", int'(wr_busy), 0);
         for (int k = 1; k <= 6; k++) begin
            if (done || stall || arr_we || arr_erase) acts++;
            @(negedge clk);
         end
         chk(acts == 0, tag, "activity after refused start", acts, 0);
      end
      mem_cmp(last ? "R5" : tag);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = DW'(i * 3 + 7);
      do_reset(2'b00);

      // table walk: short writes, refused starts, block commits
      for (int v = 0; v < NVEC; v++) begin
         logic [VW-1:0] e = VEC[v];
         string tag = e[0] ? ((e[VW-AW-DW-1 -: 0+1] == 1'b1) ? "R3" : "R3") : "R1";
         if (e[0] && e[VW-AW-1 -: 0+1] == 1'b1) tag = "R3";
         if (e[0] && e[VW-6 -: 3] == 3'd7) tag = "R4";
         if (v == 3) tag = "R2";
         if (v == 8) tag = "R9";
         run_write(e[VW-1 -: AW], e[VW-AW-1 -: DW], int'(e[3:2]), e[1], e[0], 1'b1, 1'b0, tag);
      end

      // R2: the unlock is used up by one start
      run_write(8'h20, 14'h0555, 0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
      run_write(8'h21, 14'h0556, 2, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      // R7: a following accepted start clears err
      run_write(8'h21, 14'h0556, 0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");

      // R8: key, address, data and start written during a stall are ignored
      run_write(8'h2F, 14'h02FF, 0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
      run_write(8'h2F, 14'h02FF, 2, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
      run_write(8'h2F, 14'h02FF, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");

      // R6: lower quarter protected
      do_reset(2'b01);
      run_write(8'h3D, 14'h0111, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      run_write(8'h3F, 14'h0112, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      run_write(8'h47, 14'h0222, 0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
      chk(mem[8'h45] == '1, "R6", "slot 5 untouched by refused write", int'(mem[8'h45]), int'({DW{1'b1}}));

      // R6: lower half protected
      do_reset(2'b10);
      run_write(8'h7F, 14'h0333, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      run_write(8'h87, 14'h0444, 0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");

      // R6: whole array protected
      do_reset(2'b11);
      run_write(8'hC7, 14'h0555, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
      run_write(8'h07, 14'h0666, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule